// File: doc/BRIEF.md
# Adaptive Step Sample Decoder

The block turns a stream of 8-bit delta codes into 16-bit signed samples. For every code it advances two coupled state values in a fixed order. First a table index moves by a signed amount that a per-code adjustment table gives. The index is then saturated into its legal range. Second, the saturated index selects a signed step size. The step is scaled by the code, and only the upper part of the product is kept. That value is added to a running prediction, which is saturated into the 16-bit sample range and emitted.

Codes enter and samples leave on valid/ready streams. One code is in flight at a time, so samples come out in the order the codes went in, at most one every four cycles. Both tables sit in flops and are loaded through a single write port while the decoder is idle. All state returns to zero on the active-low asynchronous reset.

Top module: `adaptive_step_decoder`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, and both the index and the prediction are zero, so the first decoded sample is computed from index 0 and prediction 0.
- R2: For each accepted code, the index becomes the old index plus the signed 8-bit adjustment entry at address code. The result is clamped to a minimum of 0 and then to a maximum of 88.
- R3: The step is the signed 16-bit entry of the step table at the clamped index. The increment is floor((step * code) / 256), with the code taken as unsigned.
- R4: The prediction plus the increment is clamped to a minimum of -32768 and then to a maximum of 32767. The clamped value is the emitted sample.
- R5: Index and prediction carry over from one sample to the next. Samples leave in the order their codes were accepted.
- R6: While out_valid_o is 1 and out_ready_i is 0, out_valid_o stays 1 and out_sample_o stays unchanged. in_ready_o is 0 while a sample is in flight or waiting to leave.
- R7: A write cycle (tbl_we_i=1) with tbl_sel_i=0 loads tbl_data_i[7:0] into adjustment entry tbl_addr_i. With tbl_sel_i=1 it loads tbl_data_i[15:0] into step entry tbl_addr_i, for addresses 0 to 88. in_ready_o is 0 in every write cycle.
- R8: A table write issued while a sample is in flight has no effect on either table.
- R9: out_valid_o rises on the third rising edge after the edge that accepts a code.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Code available |
| in_ready_o | output | 1 | Decoder idle and can take a code |
| in_code_i | input | 8 | Delta code |
| out_valid_o | output | 1 | Sample available |
| out_ready_i | input | 1 | Consumer takes the sample |
| out_sample_o | output | 16 | Decoded signed sample |
| tbl_we_i | input | 1 | Table write strobe |
| tbl_sel_i | input | 1 | 0 selects the adjustment table, 1 the step table |
| tbl_addr_i | input | 8 | Table entry address |
| tbl_data_i | input | 16 | Write data |

## Verification
A first code with empty tables shows that both state values start at zero. Runs of a maximal code against a large positive step, and of a code with a large negative adjustment against the most negative step, drive the index into both of its bounds and the prediction into both of its rails. These runs separate clamp errors from arithmetic errors. A long random code stream with a randomly stalling consumer checks that the two recurrences stay chained and that the output holds its value and order. A table write placed in the cycle after a code is accepted tells a write gate that works from one that lets a busy write corrupt the next sample.

// File: rtl/dsd_pkg.sv
package dsd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_IDX,
    ST_PRED,
    ST_OUT
  } dsd_state_e;
endpackage

// File: rtl/dsd_table.sv
module dsd_table #(
  parameter int W     = 16,
  parameter int DEPTH = 89,
  parameter int AW    = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (waddr_i == AW'(i)) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++)
      if (raddr_i == AW'(i)) rdata_o = mem_q[i];
  end
endmodule

// File: rtl/dsd_index_step.sv
module dsd_index_step #(
  parameter int ADJ_W   = 8,
  parameter int IDX_MAX = 88,
  parameter int IDX_AW  = 7
) (
  input  logic [IDX_AW-1:0]       idx_i,
  input  logic signed [ADJ_W-1:0] adj_i,
  output logic [IDX_AW-1:0]       idx_o
);
  localparam int SUM_W = ((IDX_AW > ADJ_W) ? IDX_AW : ADJ_W) + 2;

  logic signed [SUM_W-1:0] sum;

  always_comb begin
    sum = SUM_W'($signed({1'b0, idx_i})) + SUM_W'(adj_i);
    if (sum < 0)                         idx_o = '0;
    else if (sum > SUM_W'(IDX_MAX))      idx_o = IDX_AW'(IDX_MAX);
    else                                 idx_o = sum[IDX_AW-1:0];
  end
endmodule

// File: rtl/dsd_pred_step.sv
module dsd_pred_step #(
  parameter int S_W    = 16,
  parameter int CODE_W = 8
) (
  input  logic signed [S_W-1:0] pred_i,
  input  logic signed [S_W-1:0] step_i,
  input  logic [CODE_W-1:0]     code_i,
  output logic signed [S_W-1:0] pred_o
);
  localparam int PROD_W = S_W + CODE_W + 1;
  localparam int ACC_W  = S_W + 2;
  localparam logic signed [ACC_W-1:0] LO = ACC_W'(-(2 ** (S_W - 1)));
  localparam logic signed [ACC_W-1:0] HI = ACC_W'((2 ** (S_W - 1)) - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [S_W:0]      inc;
  logic signed [ACC_W-1:0]  acc;

  always_comb begin
    prod = step_i * $signed({1'b0, code_i});
    inc  = prod[PROD_W-1:CODE_W];  // high part: floor divide by 2**CODE_W
    acc  = ACC_W'(pred_i) + ACC_W'(inc);
    if (acc < LO)      pred_o = LO[S_W-1:0];
    else if (acc > HI) pred_o = HI[S_W-1:0];
    else               pred_o = acc[S_W-1:0];
  end
endmodule

// File: rtl/adaptive_step_decoder.sv
module adaptive_step_decoder #(
  parameter int CODE_W   = 8,
  parameter int SAMPLE_W = 16,
  parameter int ADJ_W    = 8,
  parameter int IDX_MAX  = 88
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [CODE_W-1:0]   in_code_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_sample_o,
  input  logic                tbl_we_i,
  input  logic                tbl_sel_i,
  input  logic [CODE_W-1:0]   tbl_addr_i,
  input  logic [SAMPLE_W-1:0] tbl_data_i
);
  import dsd_pkg::*;

  localparam int IDX_AW    = $clog2(IDX_MAX + 1);
  localparam int ADJ_DEPTH = 2 ** CODE_W;

  dsd_state_e state_q;
  logic [CODE_W-1:0]          code_q;
  logic [IDX_AW-1:0]          idx_q, idx_nxt;
  logic signed [SAMPLE_W-1:0] pred_q, pred_nxt;
  logic [ADJ_W-1:0]           adj_rd;
  logic [SAMPLE_W-1:0]        step_rd;
  logic                       idle, adj_we, step_we;

  assign idle         = (state_q == ST_IDLE);
  assign in_ready_o   = idle && !tbl_we_i;
  assign out_valid_o  = (state_q == ST_OUT);
  assign out_sample_o = pred_q;
  // writes land only while no sample is in flight
  assign adj_we       = tbl_we_i && idle && !tbl_sel_i;
  assign step_we      = tbl_we_i && idle && tbl_sel_i;

  dsd_table #(.W(ADJ_W), .DEPTH(ADJ_DEPTH), .AW(CODE_W)) u_adj_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (adj_we),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i[ADJ_W-1:0]),
    .raddr_i (code_q),
    .rdata_o (adj_rd)
  );

  dsd_table #(.W(SAMPLE_W), .DEPTH(IDX_MAX + 1), .AW(CODE_W)) u_step_tbl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (step_we),
    .waddr_i (tbl_addr_i),
    .wdata_i (tbl_data_i),
    .raddr_i (CODE_W'(idx_q)),
    .rdata_o (step_rd)
  );

  dsd_index_step #(.ADJ_W(ADJ_W), .IDX_MAX(IDX_MAX), .IDX_AW(IDX_AW)) u_idx (
    .idx_i (idx_q),
    .adj_i (adj_rd),
    .idx_o (idx_nxt)
  );

  dsd_pred_step #(.S_W(SAMPLE_W), .CODE_W(CODE_W)) u_pred (
    .pred_i (pred_q),
    .step_i (step_rd),
    .code_i (code_q),
    .pred_o (pred_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      idx_q   <= '0;
      pred_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (in_valid_i && in_ready_o) begin
          code_q  <= in_code_i;
          state_q <= ST_IDX;
        end
        ST_IDX: begin
          idx_q   <= idx_nxt;
          state_q <= ST_PRED;
        end
        ST_PRED: begin
          pred_q  <= pred_nxt;
          state_q <= ST_OUT;
        end
        ST_OUT: if (out_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsd_checker.sv
module dsd_checker #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                in_valid_i,
  input logic                in_ready_o,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [SAMPLE_W-1:0] out_sample_o,
  input logic                tbl_we_i
);
  a_r6_hold_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o);

  a_r6_hold_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> $stable(out_sample_o));

  a_r6_no_accept_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);

  a_r7_write_blocks_input: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tbl_we_i |-> !in_ready_o);

  a_r9_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o, 3));

  a_r9_no_early_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> !out_valid_o);
endmodule

bind adaptive_step_decoder dsd_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .in_valid_i   (in_valid_i),
  .in_ready_o   (in_ready_o),
  .out_valid_o  (out_valid_o),
  .out_ready_i  (out_ready_i),
  .out_sample_o (out_sample_o),
  .tbl_we_i     (tbl_we_i)
);

// File: tb/tb_adaptive_step_decoder.sv
`timescale 1ns/1ps
module tb_adaptive_step_decoder;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [7:0]  in_code = 0;
  logic        out_valid;
  logic        out_ready = 0;
  logic [15:0] out_sample;
  logic        tbl_we = 0;
  logic        tbl_sel = 0;
  logic [7:0]  tbl_addr = 0;
  logic [15:0] tbl_data = 0;

  int errors = 0;
  int checks = 0;
  int m_adj [256];
  int m_step [89];
  int m_idx = 0;
  int m_pred = 0;
  int exp_q [$];
  string tag_q [$];
  bit ready_rand = 0;

  always #10 clk = ~clk;

  adaptive_step_decoder dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_code_i(in_code),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_sample_o(out_sample),
    .tbl_we_i(tbl_we), .tbl_sel_i(tbl_sel), .tbl_addr_i(tbl_addr), .tbl_data_i(tbl_data)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // R2 R3 R4 model, evaluated in acceptance order (R5)
  task automatic send(int code, string tag);
    int idx, prod, inc, pred;
    idx = m_idx + m_adj[code];
    if (idx < 0) idx = 0;
    if (idx > 88) idx = 88;
    prod = m_step[idx] * code;
    inc = prod >>> 8;
    pred = m_pred + inc;
    if (pred < -32768) pred = -32768;
    if (pred > 32767) pred = 32767;
    m_idx = idx;
    m_pred = pred;
    exp_q.push_back(pred);
    tag_q.push_back(tag);
    @(posedge clk) #1;
    in_valid = 1;
    in_code = code[7:0];
    do @(negedge clk); while (!in_ready);
    @(posedge clk) #1;
    in_valid = 0;
  endtask

  task automatic wr(bit sel, int addr, int data);
    bit signed [7:0]  d8;
    bit signed [15:0] d16;
    do @(negedge clk); while (!in_ready);
    @(posedge clk) #1;
    tbl_we = 1; tbl_sel = sel; tbl_addr = addr[7:0]; tbl_data = data[15:0];
    @(negedge clk);
    chk(in_ready == 0, "R7 write cycle blocks input", int'(in_ready), 0);
    @(posedge clk) #1;
    tbl_we = 0;
    d8 = data[7:0];
    d16 = data[15:0];
    if (!sel) m_adj[addr] = int'(d8);
    else if (addr <= 88) m_step[addr] = int'(d16);
  endtask

  // consumer stall pattern
  initial forever begin
    @(posedge clk) #1;
    out_ready = ready_rand ? ($urandom_range(0, 3) != 0) : 1'b1;
  end

  // monitor / scoreboard
  initial begin
    bit hold_prev = 0;
    int data_prev = 0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (hold_prev) begin
          chk(out_valid == 1, "R6 valid held", int'(out_valid), 1);
          chk($signed(out_sample) == data_prev, "R6 sample held", $signed(out_sample), data_prev);
        end
        if (out_valid)
          chk(in_ready == 0, "R6 no accept while pending", int'(in_ready), 0);
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) begin
            chk(0, "R5 unexpected sample", $signed(out_sample), 0);
          end else begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk($signed(out_sample) == e, t, $signed(out_sample), e);
          end
        end
        hold_prev = out_valid && !out_ready;
        data_prev = $signed(out_sample);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R6 watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) m_adj[i] = 0;
    for (int i = 0; i < 89; i++) m_step[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0, "R1 reset out_valid", int'(out_valid), 0);
    chk(in_ready == 1, "R1 reset in_ready", int'(in_ready), 1);

    // zero tables: sample must equal reset prediction
    send(5, "R1 first sample from zero state");
    // R9 latency with a consumer always ready
    send(9, "R9 sample");
    @(negedge clk); chk(out_valid == 0, "R9 latency edge1", int'(out_valid), 0);
    @(negedge clk); chk(out_valid == 0, "R9 latency edge2", int'(out_valid), 0);
    @(negedge clk); chk(out_valid == 1, "R9 latency edge3", int'(out_valid), 1);

    // R7 load tables
    for (int c = 0; c < 256; c++) begin
      int a;
      a = ((c * 37) % 17) - 8;
      if (c == 255 || c == 200) a = 100;
      if (c == 250) a = -128;
      if (c == 7) a = 0;
      wr(0, c, a & 16'hffff);
    end
    for (int i = 0; i < 89; i++) begin
      int s;
      s = ((i * 743) % 20000) - 6000;
      if (i == 0) s = -32768;
      if (i == 88) s = 32767;
      wr(1, i, s & 16'hffff);
    end
    wr(1, 120, 16'h1234);  // out of range, no entry touched

    // R2 max clamp, R4 max rail
    send(255, "R2 index clamp max");
    send(255, "R4 prediction clamp max");
    send(200, "R4 held at max");
    // R2 min clamp, R4 min rail
    send(250, "R2 index clamp min");
    send(250, "R4 prediction descends");
    send(250, "R4 prediction clamp min");
    send(250, "R4 held at min");
    // R3 mixed codes
    send(10, "R3 step scaling");
    send(0, "R3 zero code");
    send(128, "R3 step scaling mid");
    send(1, "R3 small code floor");

    // R5 random stream with stalling consumer
    ready_rand = 1;
    for (int k = 0; k < 80; k++) send($urandom_range(0, 255), "R5 random stream");
    ready_rand = 0;

    // R8 write while busy is ignored
    send(7, "R8 setup");
    @(posedge clk) #1;
    tbl_we = 1; tbl_sel = 1; tbl_addr = m_idx[7:0]; tbl_data = 16'h7000;
    @(posedge clk) #1;
    tbl_we = 1; tbl_sel = 0; tbl_addr = 8'd7; tbl_data = 16'h0040;
    @(posedge clk) #1;
    tbl_we = 0;
    send(7, "R8 busy write ignored");
    send(7, "R8 busy write ignored again");

    while (exp_q.size() != 0) @(posedge clk);
    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule